// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on a two-wire serial bus (I2C/SMBus style) that owns a single 8-bit control register. The register's upper five bits leave the block as a DAC code, and its lower three bits drive three general-purpose digital outputs. A system clock at least 16 times faster than the bus clock oversamples both bus lines. Each line passes through a synchronizer and a small majority-free glitch filter before START, STOP and clock-edge events are derived.

A write is a three-byte transaction: the write address byte, a fixed command byte, then the new register value. A read sends the read address byte. The slave then returns a fixed lead byte of zero, followed by the register contents. The master acknowledges both bytes. Any address other than the block's own leaves the bus untouched until the next START. The data line is driven as an open-drain pull-low enable only.

Top module: `twi_ctrl_reg_slave`

## Requirements
- R1: After reset the control register is 00h, so `dac_code` and `pin_out` are zero and `sda_pull` is 0 (line released).
- R2: The 7-bit slave address is 0101100 and forms bits 7..1 of the first byte after START, with the R/W bit in bit 0 (58h write, 59h read). That byte is acknowledged by pulling SDA low in the 9th clock. Any other address gets no acknowledge, and the bus is ignored until the next START.
- R3: A write of 58h, then command AAh, then a data byte is acknowledged on all three bytes, and the data byte becomes the register value once its acknowledge bit is driven.
- R4: On a write, a command byte other than AAh is not acknowledged, the following data byte is not acknowledged either, and the register keeps its value.
- R5: After 59h is acknowledged, the slave shifts out 00h MSB first. If the master acknowledges it, the slave then shifts out the register value MSB first, changing SDA only after SCL falls.
- R6: `dac_code` equals register bits 7..3 as a raw code, with 11111 meaning the lowest analog level and 00000 the highest. `pin_out[2:0]` equals register bits 2..0, with 1 meaning high.
- R7: A STOP or START seen in the middle of a byte aborts the transaction and leaves the register unchanged. A START begins a new address byte.
- R8: The slave begins pulling SDA only while the filtered SCL is low, and releases SDA on every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (resolved wired-AND value) |
| sda_pull | output | 1 | 1 = pull the data line low, 0 = release |
| dac_code | output | 5 | Register bits 7..3, inverted-sense DAC code |
| pin_out | output | 3 | Register bits 2..0, digital output levels |

## Verification
The bench writes and reads back all 32 DAC codes with varying pin patterns. A wrong bit order or field split would show up as mismatched outputs or read data. It sends a foreign address, then a wrong command byte. A slave that acknowledged either, or let the data byte through, would corrupt the register. It also cuts a data byte short with a STOP, and then with a repeated START. A design that committed partial bytes, or failed to resynchronise on the new START, would leave a wrong value or miss the following write. The read path checks that the zero lead byte comes first and that the register value only follows a master acknowledge.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;
  localparam int REG_W = 8;
  localparam int DAC_W = 5;
  localparam int PIN_W = REG_W - DAC_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK,
    ST_TX,
    ST_MACK
  } eng_state_t;
endpackage

// File: rtl/twi_pin_filter.sv
module twi_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic q
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   q_q, q_d;

  // Output only follows the line once FILT_LEN samples agree.
  always_comb begin
    q_d = q_q;
    if (&hist_q)       q_d = 1'b1;
    else if (~|hist_q) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      q_q    <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      q_q    <= q_d;
    end
  end

  assign q = q_q;
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  =  scl_f & ~scl_p;
  assign scl_fall  = ~scl_f &  scl_p;
  assign start_evt =  scl_f &  scl_p &  sda_p & ~sda_f;
  assign stop_evt  =  scl_f &  scl_p & ~sda_p &  sda_f;
endmodule

// File: rtl/twi_xfer_engine.sv
module twi_xfer_engine
  import twi_reg_pkg::*;
#(
  parameter logic [6:0]       DEV_ADDR = 7'b0101100,
  parameter logic [REG_W-1:0] WR_CMD   = 8'hAA,
  parameter logic [REG_W-1:0] RD_LEAD  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_f,
  input  logic [REG_W-1:0] reg_q,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_data
);
  localparam int BIT_CW = $clog2(REG_W + 1);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(REG_W - 1);
  localparam logic [BIT_CW-1:0] FULL_BIT = BIT_CW'(REG_W);

  eng_state_t       state_q, state_d;
  logic [1:0]       byte_q, byte_d;
  logic [BIT_CW-1:0] bit_q, bit_d;
  logic [REG_W-1:0] sh_q, sh_d;
  logic             rw_q, rw_d;
  logic             ok_q, ok_d;
  logic             pull_q, pull_d;
  logic [REG_W-1:0] rx_byte;

  assign rx_byte = {sh_q[REG_W-2:0], sda_f};

  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    ok_d    = ok_q;
    pull_d  = pull_q;
    wr_en   = 1'b0;

    unique case (state_q)
      ST_IDLE: ;
      ST_RX: if (scl_rise) begin
        sh_d  = rx_byte;
        bit_d = bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          state_d = ST_ACK_WAIT;
          unique case (byte_q)
            2'd0: begin
              ok_d = (rx_byte[REG_W-1:1] == DEV_ADDR);
              rw_d = rx_byte[0];
              if (rx_byte[REG_W-1:1] != DEV_ADDR) state_d = ST_IDLE;
            end
            2'd1:    ok_d = (rx_byte == WR_CMD);
            default: ok_d = 1'b1;
          endcase
        end
      end
      ST_ACK_WAIT: if (scl_fall) begin
        pull_d  = ok_q;
        wr_en   = ok_q && (byte_q == 2'd2);
        state_d = ST_ACK;
      end
      ST_ACK: if (scl_fall) begin
        pull_d = 1'b0;
        bit_d  = '0;
        if (!ok_q || byte_q == 2'd2) begin
          state_d = ST_IDLE;
        end else if (byte_q == 2'd0 && rw_q) begin
          state_d = ST_TX;
          byte_d  = 2'd1;
          sh_d    = RD_LEAD;
          pull_d  = ~RD_LEAD[REG_W-1];
        end else begin
          state_d = ST_RX;
          byte_d  = byte_q + 1'b1;
        end
      end
      ST_TX: begin
        if (scl_rise) bit_d = bit_q + 1'b1;
        if (scl_fall) begin
          if (bit_q == FULL_BIT) begin
            pull_d  = 1'b0;
            state_d = ST_MACK;
          end else begin
            sh_d   = {sh_q[REG_W-2:0], 1'b0};
            pull_d = ~sh_q[REG_W-2];
          end
        end
      end
      ST_MACK: begin
        if (scl_rise) ok_d = ~sda_f;
        if (scl_fall) begin
          bit_d = '0;
          if (byte_q == 2'd1 && ok_q) begin
            state_d = ST_TX;
            byte_d  = 2'd2;
            sh_d    = reg_q;
            pull_d  = ~reg_q[REG_W-1];
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (start_evt) begin
      state_d = ST_RX;
      byte_d  = 2'd0;
      bit_d   = '0;
      pull_d  = 1'b0;
      wr_en   = 1'b0;
    end
    if (stop_evt) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
      wr_en   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      ok_q    <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      ok_q    <= ok_d;
      pull_q  <= pull_d;
    end
  end

  assign sda_pull = pull_q;
  assign wr_data  = sh_q;
endmodule

// File: rtl/twi_ctrl_reg_slave.sv
module twi_ctrl_reg_slave
  import twi_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0101100,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  output logic [DAC_W-1:0] dac_code,
  output logic [PIN_W-1:0] pin_out
);
  localparam int LINES = 2;

  logic [1:0]       rst_pipe;
  logic             rst_ni;
  logic [LINES-1:0] raw_lines, filt_q;
  logic             scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en;
  logic [REG_W-1:0] wr_data, ctrl_q, ctrl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // index 1 = SCL, index 0 = SDA
  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    twi_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_ni),
      .pin  (raw_lines[g]),
      .q    (filt_q[g])
    );
  end

  twi_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_ni),
    .scl_f    (filt_q[1]),
    .sda_f    (filt_q[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  twi_xfer_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk      (clk),
    .rst_n    (rst_ni),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_f    (filt_q[0]),
    .reg_q    (ctrl_q),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_data  (wr_data)
  );

  assign ctrl_d = wr_en ? wr_data : ctrl_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign dac_code = ctrl_q[REG_W-1:PIN_W];
  assign pin_out  = ctrl_q[PIN_W-1:0];
endmodule

// File: rtl/twi_ctrl_reg_checker.sv
module twi_ctrl_reg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] ctrl_q,
  input logic       sda_pull,
  input logic       stop_evt,
  input logic       scl_f
);
  // R7: register moves only on a committed data byte
  a_r7_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

  // R3: a commit coincides with the acknowledge being driven
  a_r3_commit_acks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_pull);

  // R8: pulling starts only while SCL is low
  a_r8_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_f);

  // R8: STOP always releases the line
  a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);
endmodule

bind twi_ctrl_reg_slave twi_ctrl_reg_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_ni),
  .wr_en   (wr_en),
  .ctrl_q  (ctrl_q),
  .sda_pull(sda_pull),
  .stop_evt(stop_evt),
  .scl_f   (filt_q[1])
);

// File: tb/sim_twi_ctrl_reg_slave.sv
module sim_twi_ctrl_reg_slave;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull;
  logic       sda_line;
  logic [4:0] dac_code;
  logic [2:0] pin_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  twi_ctrl_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .dac_code(dac_code), .pin_out(pin_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input bit b);
    tick(Q); sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; tick(2*Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack_low);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack_low = ~a;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit master_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~master_ack);
  endtask

  task automatic write_txn(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                           output bit k0, output bit k1, output bit k2);
    bus_start(); put_byte(a, k0); put_byte(c, k1); put_byte(d, k2); bus_stop();
  endtask

  task automatic read_txn(output bit k0, output logic [7:0] lead, output logic [7:0] v);
    bus_start(); put_byte(8'h59, k0); get_byte(lead, 1'b1); get_byte(v, 1'b1); bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit k0, k1, k2;
    logic [7:0] lead, rv, cur, v;
    tick(5); rst_n = 1'b1; tick(20);

    // R1: reset state
    chk(dac_code == 5'd0, "R1 dac", dac_code, 0);
    chk(pin_out == 3'd0, "R1 pins", pin_out, 0);
    chk(sda_pull == 1'b0, "R1 released", sda_pull, 0);
    read_txn(k0, lead, rv);
    chk(rv == 8'h00, "R1 readback", rv, 0);

    // R3 R5 R6: sweep all DAC codes with varying pin patterns
    for (int i = 0; i < 32; i++) begin
      v = {i[4:0], i[2:0] ^ 3'b101};
      write_txn(8'h58, 8'hAA, v, k0, k1, k2);
      chk(k0 && k1 && k2, "R3 acks", {k0, k1, k2}, 7);
      chk(dac_code == v[7:3], "R6 dac", dac_code, v[7:3]);
      chk(pin_out == v[2:0], "R6 pins", pin_out, v[2:0]);
      read_txn(k0, lead, rv);
      chk(k0, "R2 read addr ack", k0, 1);
      chk(lead == 8'h00, "R5 lead", lead, 0);
      chk(rv == v, "R5 value", rv, v);
      chk(sda_pull == 1'b0, "R8 stop release", sda_pull, 0);
    end
    cur = v;

    // R2: foreign address ignored
    write_txn(8'h5A, 8'hAA, 8'h3C, k0, k1, k2);
    chk(!k0 && !k1 && !k2, "R2 foreign nack", {k0, k1, k2}, 0);
    chk({dac_code, pin_out} == cur, "R2 unchanged", {dac_code, pin_out}, cur);

    // R4: wrong command byte
    write_txn(8'h58, 8'hAB, 8'h3C, k0, k1, k2);
    chk(k0 && !k1 && !k2, "R4 cmd nack", {k0, k1, k2}, 4);
    chk({dac_code, pin_out} == cur, "R4 unchanged", {dac_code, pin_out}, cur);

    // R7: STOP mid data byte
    bus_start(); put_byte(8'h58, k0); put_byte(8'hAA, k1);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk({dac_code, pin_out} == cur, "R7 stop abort", {dac_code, pin_out}, cur);

    // R7: repeated START mid data byte, then a full write
    bus_start(); put_byte(8'h58, k0); put_byte(8'hAA, k1);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    chk({dac_code, pin_out} == cur, "R7 partial held", {dac_code, pin_out}, cur);
    bus_start(); put_byte(8'h58, k0); put_byte(8'hAA, k1); put_byte(8'h96, k2); bus_stop();
    chk(k0 && k1 && k2, "R7 restart acks", {k0, k1, k2}, 7);
    chk({dac_code, pin_out} == 8'h96, "R7 restart write", {dac_code, pin_out}, 8'h96);

    // R6: extremes of the DAC field
    write_txn(8'h58, 8'hAA, 8'hF8, k0, k1, k2);
    chk(dac_code == 5'h1F && pin_out == 3'd0, "R6 min level code", {dac_code, pin_out}, 8'hF8);
    read_txn(k0, lead, rv);
    chk(rv == 8'hF8, "R5 final read", rv, 8'hF8);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule